// File: doc/BRIEF.md
# Scatter-Gather Stream-to-Memory Engine

This block receives packets on a byte-wide AXI4-Stream input and stores them in memory buffers that a chain of descriptors in memory describes. Each descriptor names a buffer, a capacity and the address of the next descriptor. A packet longer than one buffer continues into the following descriptors. After each descriptor is filled, the engine writes a status word back into that descriptor. The status word marks whether the descriptor holds the packet's first byte, its last byte, or both. It also records how many bytes were stored.

A second stream carries five 32-bit sideband words per packet. The engine holds them and copies them into the descriptor that receives the packet's last byte. Software-side control is reduced to a few inputs. A run level enables the engine. A current-pointer load sets where the chain starts. A tail-pointer write names the last descriptor the engine may use. The engine reports halt and idle as levels, and it reports the end of each packet as a one-cycle pulse.

Memory traffic uses a simple request port. A request is taken on a cycle where the request and ready signals are both high. Read data returns later with a valid strobe, and only one read is outstanding at a time.

Top module: `s2m_sg_top`

## Requirements
- R1: `s_tready_o` is high only while `run_i` is high, the engine is neither idle nor halted, and it is filling a descriptor; with `run_i` low or the engine idle it stays low whatever `s_tvalid_i` does.
- R2: The control stream loads five 32-bit words; once five are held, `c_tready_o` stays low until the packet's last descriptor has had its status written, after which it returns high.
- R3: A descriptor occupies nine 32-bit words at its base: +0 next pointer, +4 buffer address, +8 control (capacity in bytes in bits 22:0), +12 status, +16..+32 the five sideband words. Packet bytes are written in order to consecutive byte addresses from the buffer address; a descriptor takes at most its capacity, and the descriptor that receives the last byte takes only the bytes remaining.
- R4: If a fetched descriptor already has status bit 31 set, the engine raises `halted_o`, writes nothing, keeps `s_tready_o` low and leaves `cur_ptr_o` unchanged; only a current-pointer load clears the halt.
- R5: Status bit 27 is set in the first descriptor of a packet and clear in every later descriptor of that packet.
- R6: Every status word written has bit 31 set, and bits 22:0 hold the number of bytes stored in that descriptor's buffer.
- R7: The descriptor holding a packet's last byte gets status bit 26 and the five held sideband words, and `done_o` pulses high for exactly one cycle per packet; other descriptors get neither.
- R8: After each status write, `cur_ptr_o` takes the descriptor's next pointer; if the finished descriptor's base equaled the tail pointer, `idle_o` rises and no further descriptor is fetched until `tail_wr_i` pulses, which clears `idle_o`.
- R9: If the engine goes idle or halts in the middle of a packet, `s_tready_o` stays low; after a restart it resumes the same packet in the next descriptor, without status bit 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Channel enable level |
| cur_load_i | input | 1 | Load current descriptor pointer (taken while waiting); clears halt |
| cur_ptr_i | input | 32 | New current descriptor pointer |
| tail_wr_i | input | 1 | Write tail pointer; clears idle |
| tail_ptr_i | input | 32 | New tail descriptor pointer |
| s_tvalid_i | input | 1 | Data stream valid |
| s_tdata_i | input | 8 | Data stream byte |
| s_tlast_i | input | 1 | Last byte of packet |
| s_tready_o | output | 1 | Data stream ready |
| c_tvalid_i | input | 1 | Sideband stream valid |
| c_tdata_i | input | 32 | Sideband word |
| c_tready_o | output | 1 | Sideband stream ready |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| halted_o | output | 1 | Halted on an already-complete descriptor |
| idle_o | output | 1 | Tail descriptor finished |
| done_o | output | 1 | One-cycle end-of-packet pulse |
| cur_ptr_o | output | 32 | Current descriptor pointer |

## Verification
The bench walks packets that fit one descriptor, packets that spill into a partial third descriptor, and packets that end exactly on a descriptor boundary. A wrong remainder computation would overfill the last buffer, and a misplaced end test would tag the wrong descriptor with bit 26 or write the sideband words into it. A descriptor that is already marked complete must halt the engine without any write. A design that checks the mark too late would corrupt the buffer or advance the pointer. A packet cut by the tail pointer must hold the stream off and then resume without a second start-of-frame bit. It must also fire exactly one completion pulse. A design that forgets the packet was in flight would re-mark the start of frame or pulse twice.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int BYTE_W = 8;
  // descriptor word offsets in bytes
  localparam int OFF_STAT = 12;
  localparam int OFF_APP  = 16;
  // status bit positions
  localparam int ST_DONE_BIT = 31;
  localparam int ST_SOF_BIT  = 27;
  localparam int ST_EOF_BIT  = 26;

  typedef enum logic [3:0] {
    S_WAIT, S_RDREQ, S_RDWAIT, S_CHECK, S_DATA,
    S_WRBYTE, S_WRAPP, S_WRSTAT, S_ADV
  } eng_state_t;
endpackage

// File: rtl/s2m_appbuf.sv
module s2m_appbuf #(
  parameter int W = 32,
  parameter int N = 5,
  localparam int CW = $clog2(N + 1),
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid_i,
  input  logic [W-1:0]  in_data_i,
  output logic          in_ready_o,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_word_o,
  output logic          full_o,
  input  logic          consume_i
);
  logic [W-1:0]  words [N];
  logic [CW-1:0] cnt_q;

  assign in_ready_o = (cnt_q < CW'(N));
  assign full_o     = (cnt_q == CW'(N));
  assign rd_word_o  = words[rd_idx_i];

  // storage without reset so it maps to distributed or block RAM
  always_ff @(posedge clk) begin
    if (in_valid_i && in_ready_o) words[cnt_q[IW-1:0]] <= in_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                           cnt_q <= '0;
    else if (consume_i)                cnt_q <= '0;
    else if (in_valid_i && in_ready_o) cnt_q <= cnt_q + CW'(1);
  end

  a_r2_consume_full: assert property (@(posedge clk) disable iff (rst)
    consume_i |-> full_o);
  a_r2_fill_step: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && in_ready_o) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/s2m_engine.sv
module s2m_engine
  import s2m_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LENW = 23,
  parameter int NAPP = 5,
  localparam int AIW = $clog2(NAPP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              cur_load_i,
  input  logic [AW-1:0]     cur_ptr_i,
  input  logic              tail_wr_i,
  input  logic [AW-1:0]     tail_ptr_i,
  input  logic              s_tvalid_i,
  input  logic [BYTE_W-1:0] s_tdata_i,
  input  logic              s_tlast_i,
  output logic              s_tready_o,
  output logic [AIW-1:0]    app_idx_o,
  input  logic [31:0]       app_word_i,
  input  logic              app_full_i,
  output logic              app_consume_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              halted_o,
  output logic              idle_o,
  output logic              done_o,
  output logic [AW-1:0]     cur_ptr_o
);
  eng_state_t        state;
  logic [1:0]        rd_idx;
  logic [AIW-1:0]    app_idx_q;
  logic [AW-1:0]     cur_q, tail_q, nxt_q, buf_q;
  logic [LENW-1:0]   len_q, cnt_q;
  logic [BYTE_W-1:0] byte_q;
  logic              last_q, sof_q, eop_q, mid_q, busy_mark_q;
  logic              halted_q, idle_q, done_q;
  logic [AW-1:0]     byte_addr;
  logic [31:0]       stat_word;

  assign byte_addr = buf_q + AW'(cnt_q);

  always_comb begin
    stat_word = '0;
    stat_word[LENW-1:0]  = cnt_q;
    stat_word[ST_SOF_BIT]  = sof_q;
    stat_word[ST_EOF_BIT]  = eop_q;
    stat_word[ST_DONE_BIT] = 1'b1;
  end

  // request port decoded from registered state
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b1;
    mem_addr_o  = cur_q;
    mem_be_o    = 4'hF;
    mem_wdata_o = stat_word;
    unique case (state)
      S_RDREQ: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b0;
        mem_addr_o = cur_q + AW'({rd_idx, 2'b00});
      end
      S_WRBYTE: begin
        mem_req_o   = 1'b1;
        mem_addr_o  = {byte_addr[AW-1:2], 2'b00};
        mem_be_o    = 4'b0001 << byte_addr[1:0];
        mem_wdata_o = {4{byte_q}};
      end
      S_WRAPP: begin
        mem_req_o   = app_full_i;
        mem_addr_o  = cur_q + AW'(OFF_APP) + AW'({app_idx_q, 2'b00});
        mem_wdata_o = app_word_i;
      end
      S_WRSTAT: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(OFF_STAT);
      end
      default: ;
    endcase
  end

  assign s_tready_o    = (state == S_DATA) && run_i;
  assign app_idx_o     = app_idx_q;
  assign app_consume_o = (state == S_WRSTAT) && mem_ready_i && eop_q;
  assign halted_o      = halted_q;
  assign idle_o        = idle_q;
  assign done_o        = done_q;
  assign cur_ptr_o     = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_WAIT;
      rd_idx      <= '0;
      app_idx_q   <= '0;
      cur_q       <= '0;
      tail_q      <= '0;
      nxt_q       <= '0;
      buf_q       <= '0;
      len_q       <= '0;
      cnt_q       <= '0;
      byte_q      <= '0;
      last_q      <= 1'b0;
      sof_q       <= 1'b0;
      eop_q       <= 1'b0;
      mid_q       <= 1'b0;
      busy_mark_q <= 1'b0;
      halted_q    <= 1'b0;
      idle_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tail_wr_i) begin
        tail_q <= tail_ptr_i;
        idle_q <= 1'b0;
      end
      unique case (state)
        S_WAIT: begin
          if (cur_load_i) begin
            cur_q    <= cur_ptr_i;
            halted_q <= 1'b0;
          end else if (run_i && !halted_q && !idle_q && (s_tvalid_i || mid_q)) begin
            rd_idx <= '0;
            state  <= S_RDREQ;
          end
        end
        S_RDREQ: if (mem_ready_i) state <= S_RDWAIT;
        S_RDWAIT: begin
          if (mem_rvalid_i) begin
            unique case (rd_idx)
              2'd0:    nxt_q       <= mem_rdata_i;
              2'd1:    buf_q       <= mem_rdata_i;
              2'd2:    len_q       <= mem_rdata_i[LENW-1:0];
              default: busy_mark_q <= mem_rdata_i[ST_DONE_BIT];
            endcase
            if (rd_idx == 2'd3) state <= S_CHECK;
            else begin
              rd_idx <= rd_idx + 2'd1;
              state  <= S_RDREQ;
            end
          end
        end
        S_CHECK: begin
          if (busy_mark_q) begin
            halted_q <= 1'b1;
            state    <= S_WAIT;
          end else begin
            cnt_q <= '0;
            sof_q <= !mid_q;
            mid_q <= 1'b1;
            eop_q <= 1'b0;
            state <= (len_q == '0) ? S_WRSTAT : S_DATA;
          end
        end
        S_DATA: begin
          if (s_tvalid_i && run_i) begin
            byte_q <= s_tdata_i;
            last_q <= s_tlast_i;
            state  <= S_WRBYTE;
          end
        end
        S_WRBYTE: begin
          if (mem_ready_i) begin
            cnt_q <= cnt_q + LENW'(1);
            if (last_q) begin
              eop_q     <= 1'b1;
              app_idx_q <= '0;
              state     <= S_WRAPP;
            end else if (cnt_q + LENW'(1) == len_q) state <= S_WRSTAT;
            else                                     state <= S_DATA;
          end
        end
        S_WRAPP: begin
          if (app_full_i && mem_ready_i) begin
            if (app_idx_q == AIW'(NAPP - 1)) state <= S_WRSTAT;
            else app_idx_q <= app_idx_q + AIW'(1);
          end
        end
        S_WRSTAT: begin
          if (mem_ready_i) begin
            if (eop_q) begin
              done_q <= 1'b1;
              mid_q  <= 1'b0;
            end
            state <= S_ADV;
          end
        end
        S_ADV: begin
          cur_q <= nxt_q;
          if (cur_q == tail_q) idle_q <= 1'b1;
          state <= S_WAIT;
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  a_r1_ready_gate: assert property (@(posedge clk) disable iff (rst)
    s_tready_o |-> (run_i && !idle_q && !halted_q));
  a_r3_len_bound: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA || state == S_WRBYTE) |-> (cnt_q < len_q));
  a_r4_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted_q |-> !mem_req_o);
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (idle_q && state == S_WAIT) |=> !(mem_req_o && !mem_we_o));
endmodule

// File: rtl/s2m_sg_top.sv
module s2m_sg_top
  import s2m_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LENW = 23,
  parameter int NAPP = 5,
  localparam int AIW = $clog2(NAPP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              cur_load_i,
  input  logic [AW-1:0]     cur_ptr_i,
  input  logic              tail_wr_i,
  input  logic [AW-1:0]     tail_ptr_i,
  input  logic              s_tvalid_i,
  input  logic [BYTE_W-1:0] s_tdata_i,
  input  logic              s_tlast_i,
  output logic              s_tready_o,
  input  logic              c_tvalid_i,
  input  logic [31:0]       c_tdata_i,
  output logic              c_tready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              halted_o,
  output logic              idle_o,
  output logic              done_o,
  output logic [AW-1:0]     cur_ptr_o
);
  logic [AIW-1:0] app_idx;
  logic [31:0]    app_word;
  logic           app_full, app_consume;

  s2m_appbuf #(.W(32), .N(NAPP)) u_app (
    .clk        (clk),
    .rst        (rst),
    .in_valid_i (c_tvalid_i),
    .in_data_i  (c_tdata_i),
    .in_ready_o (c_tready_o),
    .rd_idx_i   (app_idx),
    .rd_word_o  (app_word),
    .full_o     (app_full),
    .consume_i  (app_consume)
  );

  s2m_engine #(.AW(AW), .LENW(LENW), .NAPP(NAPP)) u_eng (
    .clk           (clk),
    .rst           (rst),
    .run_i         (run_i),
    .cur_load_i    (cur_load_i),
    .cur_ptr_i     (cur_ptr_i),
    .tail_wr_i     (tail_wr_i),
    .tail_ptr_i    (tail_ptr_i),
    .s_tvalid_i    (s_tvalid_i),
    .s_tdata_i     (s_tdata_i),
    .s_tlast_i     (s_tlast_i),
    .s_tready_o    (s_tready_o),
    .app_idx_o     (app_idx),
    .app_word_i    (app_word),
    .app_full_i    (app_full),
    .app_consume_o (app_consume),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_be_o      (mem_be_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_ready_i   (mem_ready_i),
    .mem_rvalid_i  (mem_rvalid_i),
    .mem_rdata_i   (mem_rdata_i),
    .halted_o      (halted_o),
    .idle_o        (idle_o),
    .done_o        (done_o),
    .cur_ptr_o     (cur_ptr_o)
  );
endmodule

// File: tb/sim_s2m_sg_top.sv
module sim_s2m_sg_top;
  localparam int CLK_P = 10;
  localparam int NV = 4;
  // packet length, capacity of descriptor 0, 1, 2
  localparam int VEC [NV][4] = '{'{5, 16, 16, 16}, '{20, 8, 8, 8},
                                 '{16, 8, 8, 8}, '{3, 1, 1, 8}};

  logic clk = 1'b0, rst = 1'b1;
  logic run = 1'b0, cur_load = 1'b0, tail_wr = 1'b0;
  logic [31:0] cur_ptr = '0, tail_ptr = '0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0;
  logic [7:0] s_tdata = '0;
  logic s_tready;
  logic c_tvalid = 1'b0;
  logic [31:0] c_tdata = '0;
  logic c_tready;
  logic mem_req, mem_we, mem_rvalid = 1'b0, mrdy = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0] mem_be;
  logic halted, idle, done;
  logic [31:0] cur_out;
  logic pk_en = 1'b0;
  logic [31:0] pk_a = '0, pk_d = '0;
  logic [31:0] mem [256];
  int checks = 0, errors = 0, done_cnt = 0;

  always #(CLK_P / 2) clk = ~clk;

  s2m_sg_top u0 (
    .clk(clk), .rst(rst), .run_i(run), .cur_load_i(cur_load), .cur_ptr_i(cur_ptr),
    .tail_wr_i(tail_wr), .tail_ptr_i(tail_ptr), .s_tvalid_i(s_tvalid),
    .s_tdata_i(s_tdata), .s_tlast_i(s_tlast), .s_tready_o(s_tready),
    .c_tvalid_i(c_tvalid), .c_tdata_i(c_tdata), .c_tready_o(c_tready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mrdy), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .halted_o(halted), .idle_o(idle), .done_o(done),
    .cur_ptr_o(cur_out)
  );

  // memory model: ready toggles to exercise stalls, read data one cycle later
  always @(posedge clk) begin
    mrdy       <= ~mrdy;
    mem_rvalid <= 1'b0;
    if (pk_en) mem[pk_a[9:2]] <= pk_d;
    else if (mem_req && mrdy) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[9:2]];
      end
    end
    if (!rst && done) done_cnt <= done_cnt + 1;
  end

  function automatic int dsc(int i); return i * 64; endfunction
  function automatic int bfa(int i); return 256 + i * 128; endfunction
  function automatic logic [7:0] pat(int seed, int k); return 8'((seed * 37 + k * 5) & 255); endfunction
  function automatic logic [31:0] st(int n, bit s, bit e);
    return 32'h8000_0000 | (s ? 32'h0800_0000 : 32'h0) | (e ? 32'h0400_0000 : 32'h0) | 32'(n);
  endfunction
  function automatic logic [7:0] rdb(int a); return mem[a / 4][8 * (a % 4) +: 8]; endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk); pk_en = 1'b1; pk_a = 32'(a); pk_d = d;
    @(negedge clk); pk_en = 1'b0;
  endtask

  task automatic mk_descs(input int l0, input int l1, input int l2, input bit mark0);
    for (int i = 0; i < 3; i++) begin
      poke(dsc(i), 32'(dsc(i + 1)));
      poke(dsc(i) + 4, 32'(bfa(i)));
      poke(dsc(i) + 8, 32'(i == 0 ? l0 : (i == 1 ? l1 : l2)));
      poke(dsc(i) + 12, (i == 0 && mark0) ? 32'h8000_0000 : 32'h0);
      for (int k = 0; k < 5; k++) poke(dsc(i) + 16 + 4 * k, 32'h0);
    end
  endtask

  task automatic set_ptrs(input bit ld, input int cur, input int tail);
    @(negedge clk); cur_load = ld; cur_ptr = 32'(cur); tail_wr = 1'b1; tail_ptr = 32'(tail);
    @(negedge clk); cur_load = 1'b0; tail_wr = 1'b0;
  endtask

  task automatic push_ctl(input logic [31:0] w);
    @(negedge clk); c_tvalid = 1'b1; c_tdata = w;
    while (!c_tready) @(negedge clk);
    @(negedge clk); c_tvalid = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b, input bit last);
    @(negedge clk); s_tvalid = 1'b1; s_tdata = b; s_tlast = last;
    while (!s_tready) @(negedge clk);
    @(negedge clk); s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && !idle; i++) @(negedge clk);
  endtask

  task automatic send_app(input int seed);
    for (int k = 0; k < 5; k++) push_ctl(32'hA000_0000 + 32'(seed * 16 + k));
  endtask

  function automatic bit app_ok(int d, int seed);
    bit ok = 1'b1;
    for (int k = 0; k < 5; k++)
      if (mem[(d + 16 + 4 * k) / 4] !== 32'hA000_0000 + 32'(seed * 16 + k)) ok = 1'b0;
    return ok;
  endfunction

  task automatic run_vec(input int v);
    int n, seed, rem, last, pos, d0;
    int cnt[3];
    int start[3];
    bit ok;
    n = VEC[v][0]; seed = v + 1; rem = n; last = 0; pos = 0;
    for (int i = 0; i < 3; i++) begin
      cnt[i] = (VEC[v][1 + i] < rem) ? VEC[v][1 + i] : rem;
      start[i] = pos; pos += cnt[i];
      if (rem > 0 && rem - cnt[i] == 0) last = i;
      rem -= cnt[i];
    end
    mk_descs(VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
    set_ptrs(1'b1, 0, dsc(last));
    d0 = done_cnt;
    send_app(seed);
    for (int k = 0; k < n; k++) push_byte(pat(seed, k), k == n - 1);
    wait_idle();
    for (int i = 0; i <= last; i++) begin
      // R5 R6 R7: start bit on first, end bit on last, complete and count on all
      check($sformatf("R6 R5 R7 vec%0d desc%0d status", v, i), mem[(dsc(i) + 12) / 4],
            st(cnt[i], i == 0, i == last));
      ok = 1'b1;
      for (int j = 0; j < cnt[i]; j++) if (rdb(bfa(i) + j) !== pat(seed, start[i] + j)) ok = 1'b0;
      check($sformatf("R3 vec%0d desc%0d buffer bytes", v, i), 32'(ok), 32'd1);
    end
    if (last < 2) check($sformatf("R8 vec%0d unused desc untouched", v),
                        mem[(dsc(last + 1) + 12) / 4], 32'h0);
    check($sformatf("R7 vec%0d app words in last desc", v), 32'(app_ok(dsc(last), seed)), 32'd1);
    if (last > 0) check($sformatf("R7 vec%0d no app words in first desc", v),
                        mem[(dsc(0) + 16) / 4], 32'h0);
    check($sformatf("R7 vec%0d one done pulse", v), 32'(done_cnt - d0), 32'd1);
    check($sformatf("R8 vec%0d idle", v), 32'(idle), 32'd1);
    check($sformatf("R8 vec%0d cur pointer", v), cur_out, 32'(dsc(last + 1)));
    check($sformatf("R2 vec%0d control ready again", v), 32'(c_tready), 32'd1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hang expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] w_before;
    int d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R1 reset ready low", 32'(s_tready), 32'd0);
    check("R4 reset not halted", 32'(halted), 32'd0);
    check("R8 reset not idle", 32'(idle), 32'd0);
    check("R7 reset no done", 32'(done), 32'd0);
    check("R2 reset control ready", 32'(c_tready), 32'd1);

    // R1: not running, data offered, nothing accepted
    mk_descs(16, 16, 16, 1'b0);
    @(negedge clk); s_tvalid = 1'b1; s_tdata = 8'h55;
    d0 = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (s_tready || mem_req) d0++; end
    check("R1 stopped channel ready and memory quiet", 32'(d0), 32'd0);
    s_tvalid = 1'b0;
    run = 1'b1;

    // vector table walk
    for (int v = 0; v < NV; v++) run_vec(v);

    // R1: idle channel refuses data
    @(negedge clk); s_tvalid = 1'b1; s_tdata = 8'h77;
    d0 = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (s_tready) d0++; end
    check("R1 idle ready low", 32'(d0), 32'd0);
    s_tvalid = 1'b0;

    // R4: descriptor already marked complete
    mk_descs(8, 8, 8, 1'b1);
    w_before = mem[bfa(0) / 4];
    set_ptrs(1'b1, 0, dsc(0));
    @(negedge clk); s_tvalid = 1'b1; s_tdata = 8'h99; s_tlast = 1'b1;
    for (int i = 0; i < 40; i++) @(negedge clk);
    check("R4 halted raised", 32'(halted), 32'd1);
    check("R4 ready low while halted", 32'(s_tready), 32'd0);
    check("R4 status untouched", mem[(dsc(0) + 12) / 4], 32'h8000_0000);
    check("R4 buffer untouched", mem[bfa(0) / 4], w_before);
    check("R4 pointer unchanged", cur_out, 32'(dsc(0)));
    s_tvalid = 1'b0; s_tlast = 1'b0;

    // R9: packet of 12 cut by tail after first 8-byte descriptor
    mk_descs(8, 8, 8, 1'b0);
    set_ptrs(1'b1, 0, dsc(0));
    check("R4 halt cleared by pointer load", 32'(halted), 32'd0);
    d0 = done_cnt;
    send_app(9);
    check("R2 control ready low when five held", 32'(c_tready), 32'd0);
    for (int k = 0; k < 8; k++) push_byte(pat(9, k), 1'b0);
    wait_idle();
    check("R9 first part status", mem[(dsc(0) + 12) / 4], st(8, 1'b1, 1'b0));
    check("R9 no done mid packet", 32'(done_cnt - d0), 32'd0);
    check("R2 control still held mid packet", 32'(c_tready), 32'd0);
    @(negedge clk); s_tvalid = 1'b1; s_tdata = pat(9, 8);
    d0 = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (s_tready) d0++; end
    check("R9 ready low while stopped mid packet", 32'(d0), 32'd0);
    d0 = done_cnt;
    set_ptrs(1'b0, 0, dsc(1));
    for (int k = 8; k < 12; k++) push_byte(pat(9, k), k == 11);
    wait_idle();
    check("R9 resumed desc no start bit", mem[(dsc(1) + 12) / 4], st(4, 1'b0, 1'b1));
    w_before = {rdb(bfa(1) + 3), rdb(bfa(1) + 2), rdb(bfa(1) + 1), rdb(bfa(1))};
    check("R3 resumed bytes", w_before, {pat(9, 11), pat(9, 10), pat(9, 9), pat(9, 8)});
    check("R7 app words after resume", 32'(app_ok(dsc(1), 9)), 32'd1);
    check("R7 single done after resume", 32'(done_cnt - d0), 32'd1);
    check("R8 pointer after resume", cur_out, 32'(dsc(2)));
    finish_run();
  end
endmodule